// File: doc/BRIEF.md
# Complex I/Q Output Word Formatter

This block turns one complex sample from a decimating filter, a pair of 24-bit signed I and Q values, into two 16-bit output words. A control word picks one of three encodings. The first is plain fixed point: the sample is shifted right by a programmable amount and saturated. The second is a 12-bit mantissa with a 4-bit exponent. The third is an 8-bit mantissa with a 4-bit exponent. The words leave through one register stage, and a valid strobe tracks them.

In the two floating encodings, the exponent counts how many redundant sign bits were removed to normalise the value. I and Q can each take their own exponent. They can also share one exponent, set by whichever of the two has the larger magnitude, so that the pair reads as a single complex floating-point number. A force option replaces the computed exponent with the programmed scale value. Under force, any mantissa that no longer fits clips to its signed limit and never wraps.

Top module: `iq_out_formatter`

## Requirements
- R1: While `rst` is high at a clock edge, `o_vld` and both output words are cleared to zero.
- R2: `o_vld` is high exactly one clock after a cycle with `i_vld` high, and low one clock after a cycle with `i_vld` low.
- R3: With `i_fmt` = 00 (fixed point), each output word equals its input arithmetically shifted right by `i_scale` bits.
- R4: In fixed point, a shifted value outside the 16-bit signed range saturates to 32767 or -32768.
- R5: With `i_fmt` = 10 or 11, each word is {mantissa[11:0], exponent[3:0]}. Without force, the exponent is the number of leading redundant sign bits of the 24-bit input, capped at 15. The mantissa is the top 12 bits of the input shifted left by that exponent.
- R6: With `i_fmt` = 01, each word is {mantissa[7:0], 4'b0000, exponent[3:0]}. The exponent is formed as in R5, and the mantissa is the top 8 bits of the shifted input.
- R7: With `i_shared` low in a floating encoding, I and Q each take their exponent from their own value.
- R8: With `i_shared` high in a floating encoding, both components carry the smaller of the two exponents, which is the one set by the larger magnitude.
- R9: With `i_force` high in a floating encoding, both exponent fields equal `i_scale`. Each mantissa is the input multiplied by 2^`i_scale`, keeping the top mantissa bits.
- R10: Under force, a mantissa that exceeds its signed range clips to the signed maximum or minimum of its width and never wraps.
- R11: In fixed point, `i_shared` and `i_force` have no effect on the output words.
- R12: In a cycle where `i_vld` is low, the output words keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_vld | input | 1 | Input sample valid |
| i_dat_i | input | 24 | In-phase sample, signed |
| i_dat_q | input | 24 | Quadrature sample, signed |
| i_fmt | input | 2 | Encoding: 00 fixed, 01 8+4 float, 1x 12+4 float |
| i_shared | input | 1 | One exponent for both components (floating only) |
| i_force | input | 1 | Use `i_scale` as the exponent (floating only) |
| i_scale | input | 4 | Right shift in fixed point; forced exponent otherwise |
| o_vld | output | 1 | Output words valid |
| o_dat_i | output | 16 | Formatted in-phase word |
| o_dat_q | output | 16 | Formatted quadrature word |

## Verification
On every cycle the assertions check the following. The one-cycle valid latency holds. The words are held while no sample arrives. Both exponent fields match when a shared exponent was requested. The forced exponent equals the scale. The pad nibble of the 8+4 encoding is zero. Whether mantissa values are correct, whether they saturate instead of wrapping, and whether the control bits are ignored in fixed point can only be shown by the bench. It compares random and directed samples against an integer model of the encodings, including zero, full-scale values, tiny values that hit the exponent cap, and forced exponents large enough to clip.

// File: rtl/oqf_pkg.sv
package oqf_pkg;
  localparam logic [1:0] FMT_FIXED = 2'b00;
  localparam logic [1:0] FMT_F8    = 2'b01;
  localparam int         LANES     = 2;

  function automatic logic fmt_is_float(input logic [1:0] f);
    return f != FMT_FIXED;
  endfunction
endpackage

// File: rtl/oqf_sign_count.sv
module oqf_sign_count #(
  parameter int W  = 24,
  parameter int EW = 4
) (
  input  logic signed [W-1:0]  x,
  output logic        [EW-1:0] cnt
);
  localparam logic [EW-1:0] MAXE = {EW{1'b1}};

  logic run;
  always_comb begin
    cnt = '0;
    run = 1'b1;
    for (int k = W - 2; k >= 0; k--) begin
      if (run && (x[k] == x[W-1]) && (cnt != MAXE)) cnt = cnt + EW'(1);
      else run = 1'b0;
    end
  end
endmodule

// File: rtl/oqf_lane.sv
module oqf_lane
  import oqf_pkg::*;
#(
  parameter int IN_W  = 24,
  parameter int OUT_W = 16,
  parameter int EW    = 4
) (
  input  logic signed [IN_W-1:0]  x,
  input  logic        [EW-1:0]    e,
  input  logic        [1:0]       fmt,
  input  logic        [EW-1:0]    scale,
  output logic        [OUT_W-1:0] word
);
  localparam int MAXE = (1 << EW) - 1;
  localparam int WIDE = IN_W + MAXE;
  localparam int MHI  = OUT_W - EW;
  localparam int MLO  = OUT_W - 2 * EW;

  logic signed [WIDE-1:0]  xw, sh, hi_full, lo_full;
  logic signed [IN_W-1:0]  fx;
  logic        [MHI-1:0]   m_hi;
  logic        [MLO-1:0]   m_lo;
  logic        [OUT_W-1:0] w_fix;

  always_comb begin
    xw      = {{MAXE{x[IN_W-1]}}, x};
    sh      = xw <<< e;
    hi_full = sh >>> (IN_W - MHI);
    lo_full = sh >>> (IN_W - MLO);
    fx      = x >>> scale;

    if (&hi_full[WIDE-1:MHI-1] || ~|hi_full[WIDE-1:MHI-1]) m_hi = hi_full[MHI-1:0];
    else m_hi = {hi_full[WIDE-1], {(MHI-1){~hi_full[WIDE-1]}}};

    if (&lo_full[WIDE-1:MLO-1] || ~|lo_full[WIDE-1:MLO-1]) m_lo = lo_full[MLO-1:0];
    else m_lo = {lo_full[WIDE-1], {(MLO-1){~lo_full[WIDE-1]}}};

    if (&fx[IN_W-1:OUT_W-1] || ~|fx[IN_W-1:OUT_W-1]) w_fix = fx[OUT_W-1:0];
    else w_fix = {fx[IN_W-1], {(OUT_W-1){~fx[IN_W-1]}}};

    if (fmt[1])             word = {m_hi, e};
    else if (fmt == FMT_F8) word = {m_lo, {EW{1'b0}}, e};
    else                    word = w_fix;
  end
endmodule

// File: rtl/iq_out_formatter.sv
module iq_out_formatter
  import oqf_pkg::*;
#(
  parameter int IN_W  = 24,
  parameter int OUT_W = 16,
  parameter int EW    = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    i_vld,
  input  logic signed [IN_W-1:0]  i_dat_i,
  input  logic signed [IN_W-1:0]  i_dat_q,
  input  logic        [1:0]       i_fmt,
  input  logic                    i_shared,
  input  logic                    i_force,
  input  logic        [EW-1:0]    i_scale,
  output logic                    o_vld,
  output logic        [OUT_W-1:0] o_dat_i,
  output logic        [OUT_W-1:0] o_dat_q
);
  logic signed [IN_W-1:0]  x    [LANES];
  logic        [EW-1:0]    cnt  [LANES];
  logic        [EW-1:0]    esel [LANES];
  logic        [OUT_W-1:0] word [LANES];
  logic        [EW-1:0]    e_min;

  assign x[0]  = i_dat_i;
  assign x[1]  = i_dat_q;
  assign e_min = (cnt[0] < cnt[1]) ? cnt[0] : cnt[1];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    oqf_sign_count #(.W(IN_W), .EW(EW)) u_cnt (.x(x[g]), .cnt(cnt[g]));

    always_comb begin
      if (i_force)       esel[g] = i_scale;
      else if (i_shared) esel[g] = e_min;
      else               esel[g] = cnt[g];
    end

    oqf_lane #(.IN_W(IN_W), .OUT_W(OUT_W), .EW(EW)) u_lane (
      .x(x[g]), .e(esel[g]), .fmt(i_fmt), .scale(i_scale), .word(word[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld   <= 1'b0;
      o_dat_i <= '0;
      o_dat_q <= '0;
    end else begin
      o_vld <= i_vld;
      if (i_vld) begin
        o_dat_i <= word[0];
        o_dat_q <= word[1];
      end
    end
  end

  p_vld_hi_r2: assert property (@(posedge clk) disable iff (rst) i_vld |=> o_vld);
  p_vld_lo_r2: assert property (@(posedge clk) disable iff (rst) !i_vld |=> !o_vld);
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !i_vld |=> ($stable(o_dat_i) && $stable(o_dat_q)));
  p_shared_exp_r8: assert property (@(posedge clk) disable iff (rst)
    (o_vld && fmt_is_float($past(i_fmt)) && $past(i_shared))
      |-> (o_dat_i[EW-1:0] == o_dat_q[EW-1:0]));
  p_force_exp_r9: assert property (@(posedge clk) disable iff (rst)
    (o_vld && fmt_is_float($past(i_fmt)) && $past(i_force))
      |-> (o_dat_i[EW-1:0] == $past(i_scale) && o_dat_q[EW-1:0] == $past(i_scale)));
  p_pad_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (o_vld && $past(i_fmt) == FMT_F8)
      |-> (o_dat_i[2*EW-1:EW] == '0 && o_dat_q[2*EW-1:EW] == '0));
endmodule

// File: tb/sim_iq_out_formatter.sv
`timescale 1ns/1ps
module sim_iq_out_formatter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic i_vld = 1'b0;
  logic signed [23:0] i_dat_i = '0, i_dat_q = '0;
  logic [1:0] i_fmt = 2'b00;
  logic i_shared = 1'b0, i_force = 1'b0;
  logic [3:0] i_scale = '0;
  logic o_vld;
  logic [15:0] o_dat_i, o_dat_q;
  int n_run = 0, n_fail = 0;
  logic [15:0] last_i, last_q;

  always #10 clk = ~clk;

  iq_out_formatter u0 (
    .clk(clk), .rst(rst), .i_vld(i_vld), .i_dat_i(i_dat_i), .i_dat_q(i_dat_q),
    .i_fmt(i_fmt), .i_shared(i_shared), .i_force(i_force), .i_scale(i_scale),
    .o_vld(o_vld), .o_dat_i(o_dat_i), .o_dat_q(o_dat_q)
  );

  function automatic bit fits24(longint v);
    return (v >= -(64'sd1 <<< 23)) && (v < (64'sd1 <<< 23));
  endfunction

  function automatic int exp_of(int x);
    int e = 0;
    while (e < 15 && fits24(longint'(x) <<< (e + 1))) e++;
    return e;
  endfunction

  function automatic logic [15:0] ref_word(int x, int other, logic [1:0] f,
                                           logic sh, logic fo, logic [3:0] sc);
    longint v, lim;
    int e, m;
    logic [15:0] w;
    if (f == 2'b00) begin
      v = longint'(x) >>> sc;
      if (v > 32767) v = 32767;
      if (v < -32768) v = -32768;
      w = v[15:0];
    end else begin
      e = exp_of(x);
      if (sh && exp_of(other) < e) e = exp_of(other);
      if (fo) e = int'(sc);
      m = f[1] ? 12 : 8;
      v = (longint'(x) <<< e) >>> (24 - m);
      lim = 64'sd1 <<< (m - 1);
      if (v > lim - 1) v = lim - 1;
      if (v < -lim) v = -lim;
      if (m == 12) w = {v[11:0], 4'(e)};
      else         w = {v[7:0], 4'b0000, 4'(e)};
    end
    return w;
  endfunction

  function automatic string tag_of(logic [1:0] f, logic sh, logic fo);
    if (f == 2'b00) return (sh || fo) ? "R11" : "R3/R4";
    if (fo) return "R9/R10";
    if (sh) return "R8";
    return f[1] ? "R5/R7" : "R6/R7";
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(int xi, int xq, logic [1:0] f, logic sh, logic fo, logic [3:0] sc);
    logic [15:0] ei, eq;
    @(negedge clk);
    i_dat_i = xi[23:0]; i_dat_q = xq[23:0];
    i_fmt = f; i_shared = sh; i_force = fo; i_scale = sc; i_vld = 1'b1;
    ei = ref_word(xi, xq, f, sh, fo, sc);
    eq = ref_word(xq, xi, f, sh, fo, sc);
    @(negedge clk);
    i_vld = 1'b0;
    chk("R2 o_vld", {15'd0, o_vld}, 16'd1);
    chk({tag_of(f, sh, fo), " I"}, o_dat_i, ei);
    chk({tag_of(f, sh, fo), " Q"}, o_dat_q, eq);
    last_i = o_dat_i; last_q = o_dat_q;
  endtask

  function automatic int rnd24();
    logic [31:0] r = $urandom;
    int v = int'({{8{r[23]}}, r[23:0]});
    return v >>> ($urandom % 24);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 o_vld", {15'd0, o_vld}, 16'd0);
    chk("R1 o_dat_i", o_dat_i, 16'd0);
    chk("R1 o_dat_q", o_dat_q, 16'd0);
    rst = 1'b0;
    // R3/R4 fixed point corners
    send(8388607, -8388608, 2'b00, 0, 0, 4'd0);
    send(8388607, -8388608, 2'b00, 0, 0, 4'd15);
    send(32768, -32769, 2'b00, 0, 0, 4'd0);
    send(-100000, 65535, 2'b00, 0, 0, 4'd2);
    // R11: control bits ignored in fixed point
    send(123456, -98765, 2'b00, 1, 1, 4'd3);
    // R5/R6: zero, -1, full scale, exponent cap
    send(0, -1, 2'b10, 0, 0, 4'd0);
    send(0, -1, 2'b01, 0, 0, 4'd0);
    send(8388607, -8388608, 2'b11, 0, 0, 4'd0);
    send(5, -7, 2'b10, 0, 0, 4'd0);
    // R7 vs R8: separate and shared exponents
    send(3000000, 1200, 2'b10, 0, 0, 4'd0);
    send(3000000, 1200, 2'b10, 1, 0, 4'd0);
    send(-900, -2000000, 2'b01, 1, 0, 4'd0);
    // R9/R10: forced exponent, with clipping
    send(8000000, -8000000, 2'b10, 0, 1, 4'd15);
    send(8000000, -8000000, 2'b01, 1, 1, 4'd4);
    send(300, -300, 2'b10, 0, 1, 4'd6);
    // R12: outputs held while i_vld is low
    @(negedge clk);
    i_dat_i = 24'h123456; i_dat_q = 24'h654321; i_fmt = 2'b00; i_scale = 4'd0;
    @(negedge clk);
    chk("R12 o_dat_i hold", o_dat_i, last_i);
    chk("R12 o_dat_q hold", o_dat_q, last_q);
    chk("R2 o_vld low", {15'd0, o_vld}, 16'd0);
    // Random mix over all modes
    for (int n = 0; n < 400; n++) begin
      send(rnd24(), rnd24(), 2'($urandom), 1'($urandom), 1'($urandom), 4'($urandom));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule